// File: doc/BRIEF.md
# Next Program Counter Generator

This block picks the next instruction address for a 32-bit core with word-aligned instructions. Each cycle it takes the current PC, the low 26 bits of the fetched instruction, a register value for indirect jumps, two compare operands and a flow-class code from the decoder. It returns the next PC and a redirect flag that says whether control leaves the sequential path.

The block has three reaches. Conditional branches move relative to the incremented PC by a signed word offset, up to about 128 KB either way. Absolute jumps replace the low 28 bits and keep the 256 MB segment of the incremented PC. Register jumps can land anywhere in the 4 GB space.

The decision logic is combinational. An optional output register holds the result, and the default build uses it. A register jump whose value is not word-aligned sets a misalignment flag. The target is still produced with its two low bits cleared.

Top module: `npc_gen`

## Requirements
- R1: With flow class 0 (sequential), or any unused code 5, 6 or 7, next PC is cur_pc+4 and redirect is 0, whatever the compare operands and the instruction field hold.
- R2: With flow class 1 (branch if equal), when cmp_a equals cmp_b in all 32 bits, next PC is cur_pc+4 plus the sign-extended field bits [15:0] shifted left by 2, and redirect is 1. Otherwise next PC is cur_pc+4 and redirect is 0.
- R3: With flow class 2 (branch if not equal), the branch is taken when cmp_a and cmp_b differ in any bit, using the same target as R2. Otherwise next PC is cur_pc+4 and redirect is 0.
- R4: With flow class 3 (absolute jump), next PC is {(cur_pc+4)[31:28], instr_field[25:0], 2'b00} and redirect is 1.
- R5: With flow class 4 (register jump), next PC is {jreg_val[31:2], 2'b00} and redirect is 1.
- R6: A branch offset of 0x7FFF lands 131068 bytes above cur_pc+4. An offset of 0x8000 lands 131072 bytes below it.
- R7: Bits [1:0] of next_pc are always 0.
- R8: misalign is 1 only for flow class 4 with jreg_val[1:0] not zero. It is 0 in every other case.
- R9: An absolute jump taken from the last word of a 256 MB segment (cur_pc = 0x1FFFFFFC) takes its upper 4 bits from the next segment.
- R10: The cur_pc+4 increment wraps modulo 2^32, so cur_pc = 0xFFFFFFFC advances to 0x00000000.
- R11: With the output register enabled (the default), outputs reflect the inputs applied before the previous rising clock edge. While rst_n is low, next_pc equals RESET_PC (default 0) and redirect and misalign are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_pc | input | 32 | Address of the current instruction |
| instr_field | input | 26 | Low 26 bits of the instruction (jump field; bits [15:0] are the branch offset) |
| jreg_val | input | 32 | Register value for register jumps |
| cmp_a | input | 32 | First branch compare operand |
| cmp_b | input | 32 | Second branch compare operand |
| flow_cls | input | 3 | Flow class: 0 seq, 1 beq, 2 bne, 3 absolute jump, 4 register jump |
| next_pc | output | 32 | Next program counter |
| redirect | output | 1 | High when a branch is taken or a jump is decoded |
| misalign | output | 1 | Register jump target was not word-aligned |

## Verification
A wrong base address, such as the branch PC used in place of cur_pc+4, shows as a next_pc off by four on every taken branch, one cycle after the inputs. A swapped compare sense shows as redirect inverted on the very next output. A segment taken from the old PC instead of the incremented one can only be seen at a segment boundary, so that case is driven on purpose. A stale output register shows as results one vector late, and each vector is checked exactly one edge after it is applied.

// File: rtl/npc_pkg.sv
`timescale 1ns/1ps
package npc_pkg;
    parameter int XLEN = 32;

    typedef enum logic [2:0] {
        CLS_SEQ  = 3'd0,
        CLS_BEQ  = 3'd1,
        CLS_BNE  = 3'd2,
        CLS_JABS = 3'd3,
        CLS_JREG = 3'd4
    } npc_cls_e;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic            taken;
        logic            misalign;
    } npc_res_t;
endpackage

// File: rtl/npc_branch_unit.sv
`timescale 1ns/1ps
// Conditional branch: compare and PC-relative target.
module npc_branch_unit #(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16
) (
    input  logic [XLEN-1:0]  pc_plus4,
    input  logic [OFF_W-1:0] offset,
    input  logic [XLEN-1:0]  op_a,
    input  logic [XLEN-1:0]  op_b,
    input  logic             want_ne,
    output logic [XLEN-1:0]  target,
    output logic             cond
);
    localparam int EXT_W = XLEN - OFF_W - 2;

    logic [XLEN-1:0] byte_off;
    logic            same;

    always_comb begin
        // word offset -> byte offset, sign preserved
        byte_off = {{EXT_W{offset[OFF_W-1]}}, offset, 2'b00};
        target   = pc_plus4 + byte_off;
        same     = (op_a == op_b);
        cond     = want_ne ? !same : same;
    end
endmodule

// File: rtl/npc_jump_unit.sv
`timescale 1ns/1ps
// Absolute segment jump and register jump targets.
module npc_jump_unit #(
    parameter int XLEN = 32,
    parameter int JF_W = 26
) (
    input  logic [XLEN-1:0] pc_plus4,
    input  logic [JF_W-1:0] jfield,
    input  logic [XLEN-1:0] reg_val,
    output logic [XLEN-1:0] abs_target,
    output logic [XLEN-1:0] reg_target,
    output logic            reg_misalign
);
    localparam int SEG_W = XLEN - JF_W - 2;

    always_comb begin
        abs_target   = {pc_plus4[XLEN-1 -: SEG_W], jfield, 2'b00};
        reg_target   = {reg_val[XLEN-1:2], 2'b00};
        reg_misalign = |reg_val[1:0];
    end
endmodule

// File: rtl/npc_select.sv
`timescale 1ns/1ps
// Chooses among sequential, branch and jump results by flow class.
module npc_select
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [2:0]      cls,
    input  logic [XLEN-1:0] pc_plus4,
    input  logic [XLEN-1:0] br_target,
    input  logic            br_cond,
    input  logic [XLEN-1:0] abs_target,
    input  logic [XLEN-1:0] reg_target,
    input  logic            reg_misalign,
    output npc_res_t        res
);
    always_comb begin
        res.pc       = pc_plus4;
        res.taken    = 1'b0;
        res.misalign = 1'b0;
        case (cls)
            CLS_BEQ, CLS_BNE: begin
                if (br_cond) begin
                    res.pc    = br_target;
                    res.taken = 1'b1;
                end
            end
            CLS_JABS: begin
                res.pc    = abs_target;
                res.taken = 1'b1;
            end
            CLS_JREG: begin
                res.pc       = reg_target;
                res.taken    = 1'b1;
                res.misalign = reg_misalign;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/npc_gen.sv
`timescale 1ns/1ps
// Next-PC generator top: branch/jump units, selector, optional output stage.
module npc_gen
    import npc_pkg::*;
#(
    parameter int              JF_W     = 26,
    parameter int              OFF_W    = 16,
    parameter bit              REG_OUT  = 1'b1,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [JF_W-1:0] instr_field,
    input  logic [XLEN-1:0] jreg_val,
    input  logic [XLEN-1:0] cmp_a,
    input  logic [XLEN-1:0] cmp_b,
    input  logic [2:0]      flow_cls,
    output logic [XLEN-1:0] next_pc,
    output logic            redirect,
    output logic            misalign
);
    localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

    logic [XLEN-1:0] pc_plus4;
    logic [XLEN-1:0] br_target, abs_target, reg_target;
    logic            br_cond, reg_misalign, want_ne;
    npc_res_t        sel_res;
    npc_res_t        res_d, res_q;

    always_comb begin
        pc_plus4 = cur_pc + INSN_BYTES;
        want_ne  = (flow_cls == CLS_BNE);
    end

    npc_branch_unit #(.XLEN(XLEN), .OFF_W(OFF_W)) u_br (
        .pc_plus4 (pc_plus4),
        .offset   (instr_field[OFF_W-1:0]),
        .op_a     (cmp_a),
        .op_b     (cmp_b),
        .want_ne  (want_ne),
        .target   (br_target),
        .cond     (br_cond)
    );

    npc_jump_unit #(.XLEN(XLEN), .JF_W(JF_W)) u_jmp (
        .pc_plus4     (pc_plus4),
        .jfield       (instr_field),
        .reg_val      (jreg_val),
        .abs_target   (abs_target),
        .reg_target   (reg_target),
        .reg_misalign (reg_misalign)
    );

    npc_select #(.XLEN(XLEN)) u_sel (
        .cls          (flow_cls),
        .pc_plus4     (pc_plus4),
        .br_target    (br_target),
        .br_cond      (br_cond),
        .abs_target   (abs_target),
        .reg_target   (reg_target),
        .reg_misalign (reg_misalign),
        .res          (sel_res)
    );

    always_comb begin
        res_d = sel_res;
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    res_q.pc       <= RESET_PC;
                    res_q.taken    <= 1'b0;
                    res_q.misalign <= 1'b0;
                end else begin
                    res_q <= res_d;
                end
            end
        end else begin : g_comb
            always_comb res_q = res_d;
        end
    endgenerate

    always_comb begin
        next_pc  = res_q.pc;
        redirect = res_q.taken;
        misalign = res_q.misalign;
    end
endmodule

// File: rtl/npc_gen_chk.sv
`timescale 1ns/1ps
module npc_gen_chk
    import npc_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] cur_pc,
    input logic [2:0]      flow_cls,
    input logic [XLEN-1:0] jreg_val,
    input logic [XLEN-1:0] next_pc,
    input logic            redirect,
    input logic            misalign
);
    logic            primed_q;
    logic [XLEN-1:0] inc_pc;

    always_comb inc_pc = cur_pc + XLEN'(4);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed_q <= 1'b0;
        else        primed_q <= 1'b1;
    end

    generate
        if (REG_OUT) begin : g_seq
            AST_TARGET_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
                primed_q |-> (next_pc[1:0] == 2'b00)); // R7
            AST_FALLTHROUGH: assert property (@(posedge clk) disable iff (!rst_n)
                (primed_q && !redirect) |-> (next_pc == $past(inc_pc))); // R1
            AST_REG_JUMP_REACH: assert property (@(posedge clk) disable iff (!rst_n)
                (primed_q && $past(flow_cls) == CLS_JREG) |->
                (redirect && next_pc[XLEN-1:2] == $past(jreg_val[XLEN-1:2]))); // R5
            AST_MISALIGN_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
                (primed_q && misalign) |-> ($past(flow_cls) == CLS_JREG)); // R8
            AST_SEGMENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
                (primed_q && $past(flow_cls) == CLS_JABS) |->
                (redirect && next_pc[XLEN-1 -: 4] == $past(inc_pc[XLEN-1 -: 4]))); // R4
            AST_RESET_QUIET: assert property (@(posedge clk)
                !rst_n |-> (!redirect && !misalign)); // R11
        end else begin : g_imm
            always_comb begin
                if (rst_n) begin
                    AST_TARGET_ALIGNED_C: assert (next_pc[1:0] == 2'b00); // R7
                    AST_MISALIGN_SOURCE_C: assert (!misalign || flow_cls == CLS_JREG); // R8
                end
            end
        end
    endgenerate
endmodule

bind npc_gen npc_gen_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur_pc   (cur_pc),
    .flow_cls (flow_cls),
    .jreg_val (jreg_val),
    .next_pc  (next_pc),
    .redirect (redirect),
    .misalign (misalign)
);

// File: tb/sim_npc_gen.sv
`timescale 1ns/1ps
module sim_npc_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cur_pc = '0;
    logic [25:0] instr_field = '0;
    logic [31:0] jreg_val = '0;
    logic [31:0] cmp_a = '0;
    logic [31:0] cmp_b = '0;
    logic [2:0]  flow_cls = '0;
    logic [31:0] next_pc;
    logic        redirect;
    logic        misalign;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    npc_gen u0 (
        .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .instr_field(instr_field),
        .jreg_val(jreg_val), .cmp_a(cmp_a), .cmp_b(cmp_b), .flow_cls(flow_cls),
        .next_pc(next_pc), .redirect(redirect), .misalign(misalign)
    );

    localparam int NV = 16;
    localparam logic [31:0] V_PC [NV] = '{
        32'h10001010, 32'h10001010, 32'h10001010, 32'h10001010,
        32'h10001010, 32'h10001010, 32'h10001010, 32'h10001010,
        32'h1FFFFFFC, 32'h10001010, 32'h10001010, 32'hFFFFFFFC,
        32'h00400000, 32'h00400000, 32'h00400000, 32'h00400000};
    localparam logic [25:0] V_FLD [NV] = '{
        26'h0000000, 26'h0000003, 26'h0000003, 26'h000FFFF,
        26'h000FFFF, 26'h0007FFF, 26'h0008000, 26'h3FFFFFF,
        26'h0000010, 26'h0000000, 26'h0000000, 26'h0000000,
        26'h0000005, 26'h0000010, 26'h0000010, 26'h0000010};
    localparam logic [31:0] V_REG [NV] = '{
        32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
        32'h0, 32'hDEADBEEC, 32'h00000003, 32'h0,
        32'h00000001, 32'h0, 32'h0, 32'h12345678};
    localparam logic [31:0] V_A [NV] = '{
        32'h0, 32'h5, 32'h5, 32'h5, 32'h5, 32'h7, 32'h7, 32'h0,
        32'h0, 32'h0, 32'h0, 32'h0, 32'h9, 32'h80000001, 32'h80000001, 32'h1};
    localparam logic [31:0] V_B [NV] = '{
        32'h1, 32'h5, 32'h6, 32'h6, 32'h5, 32'h7, 32'h7, 32'h0,
        32'h0, 32'h0, 32'h0, 32'h0, 32'h9, 32'h00000001, 32'h00000001, 32'h2};
    localparam logic [2:0] V_CLS [NV] = '{
        3'd0, 3'd1, 3'd1, 3'd2, 3'd2, 3'd1, 3'd1, 3'd3,
        3'd3, 3'd4, 3'd4, 3'd7, 3'd0, 3'd1, 3'd2, 3'd5};
    localparam logic [31:0] E_PC [NV] = '{
        32'h10001014, 32'h10001020, 32'h10001014, 32'h10001010,
        32'h10001014, 32'h10021010, 32'h0FFE1014, 32'h1FFFFFFC,
        32'h20000040, 32'hDEADBEEC, 32'h00000000, 32'h00000000,
        32'h00400004, 32'h00400004, 32'h00400044, 32'h00400004};
    localparam logic E_TK [NV] = '{
        1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1,
        1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
    localparam logic E_MA [NV] = '{
        1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
        1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
    localparam string V_TAG [NV] = '{
        "R1", "R2", "R2", "R3", "R3", "R6", "R6", "R4",
        "R9", "R5", "R8", "R10", "R1", "R2", "R3", "R1"};

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic apply(input int i);
        cur_pc      = V_PC[i];
        instr_field = V_FLD[i];
        jreg_val    = V_REG[i];
        cmp_a       = V_A[i];
        cmp_b       = V_B[i];
        flow_cls    = V_CLS[i];
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R11 reset state, with non-idle inputs applied
        apply(9);
        repeat (3) @(negedge clk);
        check("R11", "reset next_pc", next_pc, 32'h0);
        check("R11", "reset redirect", {31'b0, redirect}, 32'h0);
        check("R11", "reset misalign", {31'b0, misalign}, 32'h0);
        rst_n = 1'b1;

        // vector table: drive at a falling edge, sample at the next one
        for (int i = 0; i < NV; i++) begin
            apply(i);
            @(negedge clk);
            check(V_TAG[i], "next_pc", next_pc, E_PC[i]);
            check(V_TAG[i], "redirect", {31'b0, redirect}, {31'b0, E_TK[i]});
            check(V_TAG[i], "misalign", {31'b0, misalign}, {31'b0, E_MA[i]});
            check("R7", "low bits", {30'b0, next_pc[1:0]}, 32'h0);
        end

        // R11 one-cycle latency: a change between edges is not visible yet
        apply(1);
        @(negedge clk);
        apply(7);
        #2;
        check("R11", "held before edge", next_pc, 32'h10001020);
        @(negedge clk);
        check("R11", "updated after edge", next_pc, 32'h1FFFFFFC);

        // R8 misalign clears on the next aligned register jump
        jreg_val = 32'h00000002;
        flow_cls = 3'd4;
        @(negedge clk);
        check("R8", "misalign set", {31'b0, misalign}, 32'h1);
        check("R5", "cleared low bits", next_pc, 32'h00000000);
        jreg_val = 32'hFFFFFFF0;
        @(negedge clk);
        check("R8", "misalign clear", {31'b0, misalign}, 32'h0);
        check("R5", "full reach", next_pc, 32'hFFFFFFF0);

        // R11 reset reasserted mid-run
        rst_n = 1'b0;
        #2;
        check("R11", "async reset pc", next_pc, 32'h0);
        check("R11", "async reset redirect", {31'b0, redirect}, 32'h0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule